// File: doc/BRIEF.md
# Mailbox Doorbell Console Endpoint

This block is the local end of a byte-wide console link that runs across a bus bridge. The link uses two 32-bit mailbox registers, one for each direction, and two doorbell registers. Bytes from a local valid/ready stream go into the outgoing mailbox with a valid marker, one at a time. After each byte the endpoint rings the outbound doorbell with a data code. It then waits for the far side to clear the mailbox before it sends another byte. A newline is always followed by an added carriage return.

On the inbound side the endpoint acts on doorbell events, but only while the doorbell bit of the bridge interrupt status is set. It decodes the message code and acknowledges each event once. Data bytes go into a 256-entry ring, which a local valid/ready reader drains. Flow control works by withholding the clear of the inbound mailbox while the ring is nearly full. Keep-alive pings are echoed. A connect message flushes the ring and raises the link flag. A local disconnect request sends a disconnect code and drops the link flag. Codes that the endpoint does not know set a sticky error flag.

Top module: `mbx_con_endpoint`

## Requirements
- R1: `tx_ready` is high only while no byte is in flight, and it is high out of reset. An accepted byte is written to the outgoing mailbox as `{1'b1, 23'b0, byte}`. The write happens only in a cycle where the outgoing mailbox reads zero.
- R2: Every outgoing mailbox write is followed by exactly one outbound doorbell write of code 0x5, and it comes before the next mailbox write.
- R3: An accepted byte 0x0A is followed automatically by a separate mailbox write of byte 0x0D. The 0x0D write follows the same mailbox-free and doorbell rules as any other byte.
- R4: An inbound event is taken only while `db_irq` is high. Each event produces exactly one acknowledge pulse on `ib_db_we`, with `ib_db_wd` equal to all ones.
- R5: Inbound code 0x1 causes one outbound doorbell write of code 0x1. The acknowledge is issued in the same cycle as that echo.
- R6: Inbound code 0x2 empties the ring and clears the hold state. It pulses `rx_mbox_clr`, and from the next cycle `link_up` is 1. A pop requested in the same cycle is discarded.
- R7: Inbound code 0x5 stores `rx_mbox_byte` in the ring. If the ring then holds at most 252 entries, `rx_mbox_clr` pulses in the same cycle. Otherwise the ring enters the hold state and the mailbox is not cleared.
- R8: While the ring is in the hold state, a pop that leaves fewer than 252 entries ends the hold state and pulses `rx_mbox_clr`. A pop that leaves exactly 252 entries does neither.
- R9: A pulse on `disc_req` sends outbound doorbell code 0x3 and clears `link_up` from the next cycle.
- R10: Any inbound code other than 0x1, 0x2 and 0x5 is acknowledged and sets `bad_code`, which stays set until reset. The ring is left unchanged.
- R11: At most one outbound doorbell write happens per cycle. The priority is keep-alive echo, then disconnect, then data. A request that loses arbitration is held until it is served.
- R12: `rx_valid` is high exactly when the ring is not empty. `rx_data` is the oldest stored byte, and bytes leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Local transmit byte valid |
| tx_data | input | 8 | Local transmit byte |
| tx_ready | output | 1 | Endpoint accepts a transmit byte |
| rx_valid | output | 1 | Ring holds at least one byte |
| rx_data | output | 8 | Oldest ring byte |
| rx_ready | input | 1 | Local reader takes the byte |
| disc_req | input | 1 | Request to send a disconnect |
| link_up | output | 1 | Link marked connected |
| bad_code | output | 1 | Sticky unknown-code flag |
| tx_mbox_q | input | 32 | Current outgoing mailbox value |
| tx_mbox_we | output | 1 | Outgoing mailbox write strobe |
| tx_mbox_wd | output | 32 | Outgoing mailbox write data |
| rx_mbox_byte | input | 8 | Low byte of the inbound mailbox |
| rx_mbox_clr | output | 1 | Write zero to the inbound mailbox |
| db_irq | input | 1 | Inbound doorbell bit (bit 20) of the bridge interrupt status |
| ib_db_q | input | 32 | Inbound doorbell message code |
| ib_db_we | output | 1 | Inbound doorbell acknowledge strobe |
| ib_db_wd | output | 32 | Acknowledge data, all ones |
| ob_db_we | output | 1 | Outbound doorbell write strobe |
| ob_db_code | output | 32 | Outbound doorbell code |

## Verification
The keep-alive echo and the data doorbell of a byte just written can ask for the outbound doorbell in the same cycle. The bench starts a transmit byte and raises a keep-alive event with a lag of zero to three cycles, so that the two requests overlap. For each lag it checks that exactly one 0x1 and exactly one 0x5 reach the doorbell, and that no write is lost. A ring push and a local pop can also fall in one cycle, including the case where a pop ends the hold state. A behavioural queue model checks the mailbox clear strobe and the ring outputs on every clock during those overlaps.

// File: rtl/mbx_con_pkg.sv
package mbx_con_pkg;

  localparam logic [31:0] CODE_PING = 32'h1;
  localparam logic [31:0] CODE_LINK = 32'h2;
  localparam logic [31:0] CODE_DROP = 32'h3;
  localparam logic [31:0] CODE_DATA = 32'h5;

  localparam logic [7:0] CH_NL = 8'h0A;
  localparam logic [7:0] CH_CR = 8'h0D;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_RING} tx_st_e;
  typedef enum logic [1:0] {HD_IDLE, HD_EXEC, HD_DRAIN} hd_st_e;

  // occupancy after one cycle of push/pop
  function automatic logic [15:0] occ_after(logic [15:0] occ, logic add, logic sub);
    return occ + {15'b0, add} - {15'b0, sub};
  endfunction

  // strictly above the high-water mark: withhold the mailbox
  function automatic logic above_mark(logic [15:0] occ, logic [15:0] depth, logic [15:0] rsv);
    return occ > (depth - rsv);
  endfunction

  // strictly below the mark: release the mailbox
  function automatic logic below_mark(logic [15:0] occ, logic [15:0] depth, logic [15:0] rsv);
    return occ < (depth - rsv);
  endfunction

  // ring pointer advance for any depth
  function automatic logic [15:0] ptr_next(logic [15:0] p, logic [15:0] depth);
    return (p == depth - 16'd1) ? 16'd0 : p + 16'd1;
  endfunction

endpackage

// File: rtl/mbx_con_tx.sv
module mbx_con_tx
  import mbx_con_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MBOX_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic [MBOX_W-1:0] mbox_q,
  output logic              mbox_we,
  output logic [MBOX_W-1:0] mbox_wd,
  output logic              ring_req,
  input  logic              ring_gnt
);
  localparam int PAD_W = MBOX_W - DATA_W - 1;

  tx_st_e            st;
  logic [DATA_W-1:0] ch;
  logic              cr_pend;
  logic              mbox_free;

  assign mbox_free = (mbox_q == '0);
  assign s_ready   = (st == TX_IDLE);
  assign mbox_we   = (st == TX_WAIT) && mbox_free;
  assign mbox_wd   = {1'b1, {PAD_W{1'b0}}, ch};
  assign ring_req  = (st == TX_RING);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      ch      <= '0;
      cr_pend <= 1'b0;
    end else begin
      unique case (st)
        TX_IDLE: if (s_valid) begin
          ch      <= s_data;
          cr_pend <= (s_data == DATA_W'(CH_NL));
          st      <= TX_WAIT;
        end
        TX_WAIT: if (mbox_free) st <= TX_RING;
        TX_RING: if (ring_gnt) begin
          if (cr_pend) begin
            ch      <= DATA_W'(CH_CR);
            cr_pend <= 1'b0;
            st      <= TX_WAIT;
          end else begin
            st <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R2
  tx_one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_we |=> (ring_req && !mbox_we));
  // R11
  tx_ring_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_req && !ring_gnt) |=> ring_req);

endmodule

// File: rtl/mbx_con_ring.sv
module mbx_con_ring
  import mbx_con_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int RSV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_rdy,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              mbox_clr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [15:0] DEPTH16 = 16'(DEPTH);
  localparam logic [15:0] RSV16   = 16'(RSV);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count, occ_nx;
  logic              held;
  logic              pop_fire, push_ok, set_hold, release_hold;

  assign out_valid    = (count != '0);
  assign out_data     = mem[rd_ptr];
  assign pop_fire     = out_valid && pop_rdy && !flush;
  assign push_ok      = push && !flush && (count < CW'(DEPTH));
  assign occ_nx       = CW'(occ_after(16'(count), push_ok, pop_fire));
  assign set_hold     = push_ok && above_mark(16'(occ_nx), DEPTH16, RSV16);
  assign release_hold = held && pop_fire && !push_ok && below_mark(16'(occ_nx), DEPTH16, RSV16);
  assign mbox_clr     = flush || (push_ok && !set_hold) || release_hold;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      held   <= 1'b0;
    end else begin
      if (push_ok)  wr_ptr <= AW'(ptr_next(16'(wr_ptr), DEPTH16));
      if (pop_fire) rd_ptr <= AW'(ptr_next(16'(rd_ptr), DEPTH16));
      count <= occ_nx;
      if (set_hold)          held <= 1'b1;
      else if (release_hold) held <= 1'b0;
    end
  end

  // R7
  ring_hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (count >= CW'(DEPTH - RSV)));
  // R6
  ring_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !held));
  // R12
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/mbx_con_inbound.sv
module mbx_con_inbound
  import mbx_con_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MBOX_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_irq,
  input  logic [MBOX_W-1:0] db_code,
  input  logic [DATA_W-1:0] mbox_byte,
  input  logic              ping_gnt,
  output logic              ping_req,
  output logic              flush,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              ack,
  output logic              bad
);
  hd_st_e            st;
  logic [MBOX_W-1:0] code_q;
  logic              in_exec, is_ping, is_link, is_data, is_bad, done;

  assign in_exec   = (st == HD_EXEC);
  assign is_ping   = (code_q == MBOX_W'(CODE_PING));
  assign is_link   = (code_q == MBOX_W'(CODE_LINK));
  assign is_data   = (code_q == MBOX_W'(CODE_DATA));
  assign is_bad    = !(is_ping || is_link || is_data);
  assign done      = in_exec && (!is_ping || ping_gnt);
  assign ping_req  = in_exec && is_ping;
  assign flush     = in_exec && is_link;
  assign push      = in_exec && is_data;
  assign push_data = mbox_byte;
  assign ack       = done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= HD_IDLE;
      code_q <= '0;
      bad    <= 1'b0;
    end else begin
      unique case (st)
        HD_IDLE: if (db_irq) begin
          code_q <= db_code;
          st     <= HD_EXEC;
        end
        HD_EXEC: if (done) begin
          if (is_bad) bad <= 1'b1;
          st <= HD_DRAIN;
        end
        HD_DRAIN: if (!db_irq) st <= HD_IDLE;
        default: st <= HD_IDLE;
      endcase
    end
  end

  // R4
  in_single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R6
  in_link_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ack);
  // R10
  in_bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> bad);

endmodule

// File: rtl/mbx_con_endpoint.sv
module mbx_con_endpoint
  import mbx_con_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MBOX_W = 32,
  parameter int DEPTH  = 256,
  parameter int RSV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              disc_req,
  output logic              link_up,
  output logic              bad_code,
  input  logic [MBOX_W-1:0] tx_mbox_q,
  output logic              tx_mbox_we,
  output logic [MBOX_W-1:0] tx_mbox_wd,
  input  logic [DATA_W-1:0] rx_mbox_byte,
  output logic              rx_mbox_clr,
  input  logic              db_irq,
  input  logic [MBOX_W-1:0] ib_db_q,
  output logic              ib_db_we,
  output logic [MBOX_W-1:0] ib_db_wd,
  output logic              ob_db_we,
  output logic [MBOX_W-1:0] ob_db_code
);
  // internal events brought out for the checks
  logic              data_ring_req, data_ring_gnt;
  logic              ping_req, ping_gnt;
  logic              drop_pend, drop_gnt;
  logic              ring_flush, ring_push;
  logic [DATA_W-1:0] ring_push_data;

  mbx_con_tx #(.DATA_W(DATA_W), .MBOX_W(MBOX_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (tx_valid),
    .s_data   (tx_data),
    .s_ready  (tx_ready),
    .mbox_q   (tx_mbox_q),
    .mbox_we  (tx_mbox_we),
    .mbox_wd  (tx_mbox_wd),
    .ring_req (data_ring_req),
    .ring_gnt (data_ring_gnt)
  );

  mbx_con_inbound #(.DATA_W(DATA_W), .MBOX_W(MBOX_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_irq    (db_irq),
    .db_code   (ib_db_q),
    .mbox_byte (rx_mbox_byte),
    .ping_gnt  (ping_gnt),
    .ping_req  (ping_req),
    .flush     (ring_flush),
    .push      (ring_push),
    .push_data (ring_push_data),
    .ack       (ib_db_we),
    .bad       (bad_code)
  );

  mbx_con_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RSV(RSV)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (ring_flush),
    .push      (ring_push),
    .push_data (ring_push_data),
    .pop_rdy   (rx_ready),
    .out_valid (rx_valid),
    .out_data  (rx_data),
    .mbox_clr  (rx_mbox_clr)
  );

  assign ib_db_wd = '1;

  // outbound doorbell arbitration: echo, then disconnect, then data
  assign ping_gnt      = ping_req;
  assign drop_gnt      = drop_pend && !ping_req;
  assign data_ring_gnt = data_ring_req && !ping_req && !drop_pend;
  assign ob_db_we      = ping_gnt || drop_gnt || data_ring_gnt;

  always_comb begin
    ob_db_code = '0;
    if (ping_gnt)           ob_db_code = MBOX_W'(CODE_PING);
    else if (drop_gnt)      ob_db_code = MBOX_W'(CODE_DROP);
    else if (data_ring_gnt) ob_db_code = MBOX_W'(CODE_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_pend <= 1'b0;
      link_up   <= 1'b0;
    end else begin
      if (disc_req)      drop_pend <= 1'b1;
      else if (drop_gnt) drop_pend <= 1'b0;
      if (ring_flush)    link_up <= 1'b1;
      else if (disc_req) link_up <= 1'b0;
    end
  end

  // R11
  ob_single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ping_gnt, drop_gnt, data_ring_gnt}));
  // R11
  ob_drop_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pend && !drop_gnt && !disc_req) |=> drop_pend);
  // R9
  ob_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ob_db_we |-> (ob_db_code == MBOX_W'(CODE_PING) || ob_db_code == MBOX_W'(CODE_DROP)
                  || ob_db_code == MBOX_W'(CODE_DATA)));
  // R5
  ob_echo_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ping_gnt |-> ib_db_we);

endmodule

// File: tb/mbx_con_endpoint_tb.sv
module mbx_con_endpoint_tb;
  localparam int DEPTH = 256;
  localparam int MARK  = DEPTH - 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, tx_valid, tx_ready, rx_valid, rx_ready, disc_req, link_up, bad_code;
  logic [7:0]  tx_data, rx_data;
  logic [31:0] tx_mbox_q, tx_mbox_wd, rx_mbox_q, ib_db_q, ib_db_wd, ob_db_code;
  logic        tx_mbox_we, rx_mbox_clr, db_irq, ib_db_we, ob_db_we;

  // far-side controls
  logic        far_auto, far_rx_wr, far_db_wr, far_irq_val;
  logic [31:0] far_rx_val, far_db_val;
  int          far_lat, hold;

  mbx_con_endpoint u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .disc_req(disc_req),
    .link_up(link_up), .bad_code(bad_code), .tx_mbox_q(tx_mbox_q), .tx_mbox_we(tx_mbox_we),
    .tx_mbox_wd(tx_mbox_wd), .rx_mbox_byte(rx_mbox_q[7:0]), .rx_mbox_clr(rx_mbox_clr),
    .db_irq(db_irq), .ib_db_q(ib_db_q), .ib_db_we(ib_db_we), .ib_db_wd(ib_db_wd),
    .ob_db_we(ob_db_we), .ob_db_code(ob_db_code)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bridge registers
  always @(posedge clk) begin
    if (!rst_n) begin
      tx_mbox_q <= '0; rx_mbox_q <= '0; db_irq <= 1'b0; ib_db_q <= '0; hold <= 0;
    end else begin
      if (tx_mbox_we) begin
        tx_mbox_q <= tx_mbox_wd; hold <= 0;
      end else if (tx_mbox_q != 0 && far_auto) begin
        if (hold >= far_lat) begin tx_mbox_q <= '0; hold <= 0; end
        else hold <= hold + 1;
      end
      if (rx_mbox_clr) rx_mbox_q <= '0;
      else if (far_rx_wr) rx_mbox_q <= far_rx_val;
      if (ib_db_we) db_irq <= 1'b0;
      else if (far_db_wr) begin db_irq <= far_irq_val; ib_db_q <= far_db_val; end
    end
  end

  // behavioural reference model
  logic [7:0]  mq[$];
  logic [31:0] db_log[$], tx_log[$];
  bit          m_link, m_err, m_held, model_on, ring_owed;
  int          acks;

  always @(negedge clk) begin
    if (model_on) begin
      bit ack, pop, push, conn, exp_clr;
      int after;
      chk(rx_valid === (mq.size() != 0), "R12 rx_valid", 32'(rx_valid), 32'(mq.size() != 0));
      if (mq.size() != 0) chk(rx_data === mq[0], "R12 rx_data", 32'(rx_data), 32'(mq[0]));
      chk(link_up === m_link, "R6 R9 link_up", 32'(link_up), 32'(m_link));
      chk(bad_code === m_err, "R10 bad_code", 32'(bad_code), 32'(m_err));
      chk(ib_db_wd === 32'hFFFF_FFFF, "R4 ack data", ib_db_wd, 32'hFFFF_FFFF);
      ack  = ib_db_we;
      conn = ack && ib_db_q == 32'h2;
      pop  = rx_ready && mq.size() != 0 && !conn;
      push = ack && ib_db_q == 32'h5 && mq.size() < DEPTH;
      after = mq.size() + int'(push) - int'(pop);
      if (conn) begin
        exp_clr = 1'b1;
      end else begin
        exp_clr = (push && after <= MARK) || (m_held && pop && !push && after < MARK);
      end
      chk(rx_mbox_clr === exp_clr, "R7 R8 mailbox clear", 32'(rx_mbox_clr), 32'(exp_clr));
      if (conn) begin
        mq.delete(); m_held = 0; m_link = 1;
      end else begin
        if (pop) void'(mq.pop_front());
        if (push) begin
          mq.push_back(rx_mbox_q[7:0]);
          if (after > MARK) m_held = 1;
        end else if (m_held && pop && after < MARK) m_held = 0;
        if (disc_req) m_link = 0;
      end
      if (ack && !(ib_db_q inside {32'h1, 32'h2, 32'h5})) m_err = 1;
      if (ack) acks++;
      if (ob_db_we) begin
        db_log.push_back(ob_db_code);
        if (ob_db_code == 32'h5) begin
          chk(ring_owed, "R2 data doorbell after write", 0, 1);
          ring_owed = 0;
        end
      end
      if (tx_mbox_we) begin
        chk(tx_mbox_q == 0, "R1 write only into empty mailbox", tx_mbox_q, 0);
        chk(!ring_owed, "R2 no second write before doorbell", 1, 0);
        ring_owed = 1;
        tx_log.push_back(tx_mbox_wd);
      end
    end
  end

  task automatic ev(input logic [31:0] code, input logic [7:0] b, input bit irq = 1'b1);
    @(posedge clk); #1;
    far_db_val = code; far_irq_val = irq; far_db_wr = 1'b1;
    far_rx_wr = (code == 32'h5); far_rx_val = {1'b1, 23'b0, b};
    @(posedge clk); #1;
    far_db_wr = 1'b0; far_rx_wr = 1'b0;
    if (irq) do @(negedge clk); while (db_irq);
  endtask

  task automatic send_tx(input logic [7:0] c);
    @(posedge clk); #1;
    tx_valid = 1'b1; tx_data = c;
    do @(negedge clk); while (!tx_ready);
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic pop_n(input int n);
    @(posedge clk); #1 rx_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1 rx_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int count_code(input logic [31:0] c);
    int n = 0;
    foreach (db_log[i]) if (db_log[i] == c) n++;
    return n;
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    summary();
  end

  initial begin
    int a0;
    logic [31:0] exp_tx[$];
    rst_n = 0; tx_valid = 0; tx_data = 0; rx_ready = 0; disc_req = 0;
    far_auto = 0; far_lat = 3; far_rx_wr = 0; far_db_wr = 0; far_irq_val = 0;
    far_rx_val = 0; far_db_val = 0;
    m_link = 0; m_err = 0; m_held = 0; model_on = 0; ring_owed = 0; acks = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // reset state
    chk(tx_ready === 1'b1, "R1 reset tx_ready", 32'(tx_ready), 1);
    chk(rx_valid === 1'b0, "R12 reset rx_valid", 32'(rx_valid), 0);
    chk(link_up === 1'b0 && bad_code === 1'b0, "R6 R10 reset flags", 32'({link_up, bad_code}), 0);
    chk(!ob_db_we && !tx_mbox_we && !ib_db_we, "R11 reset strobes", 32'({ob_db_we, tx_mbox_we, ib_db_we}), 0);
    model_on = 1;

    // R6 connect
    ev(32'h2, 0); idle(2);
    chk(link_up === 1'b1, "R6 link after connect", 32'(link_up), 1);

    // R5 keep-alive echo, R4 single ack
    db_log.delete(); a0 = acks;
    ev(32'h1, 0); idle(3);
    chk(db_log.size() == 1 && db_log[0] == 32'h1, "R5 echo code", db_log.size() > 0 ? db_log[0] : 0, 1);
    chk(acks == a0 + 1, "R4 one ack per event", acks - a0, 1);

    // R4 gate: code present, doorbell bit low
    db_log.delete(); a0 = acks;
    ev(32'h1, 0, 1'b0); idle(20);
    chk(acks == a0 && db_log.size() == 0, "R4 no action without db_irq", acks - a0 + db_log.size(), 0);

    // R7 R12 data, order
    ev(32'h5, 8'h41); ev(32'h5, 8'h42); ev(32'h5, 8'h43);
    chk(rx_mbox_q == 0, "R7 mailbox cleared below mark", rx_mbox_q, 0);
    chk(mq.size() == 3 && rx_data == 8'h41, "R12 head byte", 32'(rx_data), 32'h41);
    pop_n(3); idle(1);
    chk(rx_valid === 1'b0, "R12 drained", 32'(rx_valid), 0);

    // R10 unknown code
    ev(32'h5, 8'h77); ev(32'h7, 0); idle(2);
    chk(bad_code === 1'b1, "R10 sticky flag", 32'(bad_code), 1);
    chk(mq.size() == 1 && rx_data == 8'h77, "R10 ring unchanged", 32'(rx_data), 32'h77);
    pop_n(1);

    // R1 R2 R3 transmit with newline expansion
    far_auto = 1; far_lat = 3; db_log.delete(); tx_log.delete();
    send_tx(8'h41); send_tx(8'h0A); send_tx(8'h42); idle(30);
    exp_tx = '{32'h8000_0041, 32'h8000_000A, 32'h8000_000D, 32'h8000_0042};
    chk(tx_log.size() == 4, "R3 four mailbox writes", tx_log.size(), 4);
    foreach (exp_tx[i]) if (i < tx_log.size())
      chk(tx_log[i] == exp_tx[i], "R1 R3 mailbox word", tx_log[i], exp_tx[i]);
    chk(count_code(32'h5) == 4 && db_log.size() == 4, "R2 data doorbells", count_code(32'h5), 4);

    // R11 collision sweep: data doorbell against keep-alive echo
    for (int off = 0; off < 4; off++) begin
      db_log.delete(); far_lat = 1;
      fork
        send_tx(8'h55);
        begin idle(off); ev(32'h1, 0); end
      join
      idle(20);
      chk(count_code(32'h1) == 1, "R11 echo not lost", count_code(32'h1), 1);
      chk(count_code(32'h5) == 1, "R11 data doorbell not lost", count_code(32'h5), 1);
    end

    // R9 disconnect, overlapped with a keep-alive
    db_log.delete();
    fork
      begin @(posedge clk); #1 disc_req = 1; @(posedge clk); #1 disc_req = 0; end
      ev(32'h1, 0);
    join
    idle(5);
    chk(count_code(32'h3) == 1, "R9 disconnect code", count_code(32'h3), 1);
    chk(count_code(32'h1) == 1, "R11 echo beside disconnect", count_code(32'h1), 1);
    chk(link_up === 1'b0, "R9 link dropped", 32'(link_up), 0);

    // R6 connect flushes pending data
    ev(32'h2, 0); ev(32'h5, 8'h10); ev(32'h5, 8'h11); ev(32'h2, 0); idle(1);
    chk(rx_valid === 1'b0, "R6 ring flushed", 32'(rx_valid), 0);

    // R7 R8 fill to the mark
    for (int i = 0; i < MARK + 1; i++) ev(32'h5, 8'(i));
    chk(mq.size() == MARK + 1, "R7 ring level", mq.size(), MARK + 1);
    chk(rx_mbox_q == 32'h8000_00FC, "R7 mailbox withheld", rx_mbox_q, 32'h8000_00FC);
    pop_n(1); idle(1);
    chk(rx_mbox_q != 0, "R8 still held at mark", rx_mbox_q, 32'h8000_00FC);
    pop_n(1); idle(1);
    chk(rx_mbox_q == 0, "R8 released below mark", rx_mbox_q, 0);
    chk(rx_data == 8'h02, "R12 order after drain", 32'(rx_data), 2);
    pop_n(MARK - 1); idle(2);
    chk(rx_valid === 1'b0, "R12 fully drained", 32'(rx_valid), 0);

    summary();
  end
endmodule